// File: doc/BRIEF.md
# Embedded Word-Clock Serializer

This block takes a parallel data word, captured on each rising edge of a strobe, and sends it one bit at a time over a serial data line. A source-synchronous serial clock line goes with it. No separate frame or sync line is used. Word framing lives in the serial clock: at the end of each word the clock skips its low phases, and two boundary bits derived from the last data bit are appended. A receiver can therefore find the word edge from the clock and data lines alone.

The block runs from a system clock. A half-bit clock enable (`phase_ce`) stands in for the bit-rate generator, so every serial bit is made of one low phase followed by one high phase. Each transmission slot is 26 bits long, which sets the reference word rate. A strobe that arrives while a word is still being sent is held in a single-word buffer, and a sticky flag reports words that had to be dropped. Slots with no captured word carry zeros under a free-running clock. An input option clears the two top data bits, for systems that use those bit positions for dedicated signals.

Top module: `emb_clk_serializer`

## Requirements
- R1: After reset, `ser_clk` is 1, `ser_data` is 0, `ser_oe` is 0 and `overflow` is 0.
- R2: While `enable` is 1, a word is captured only on a clock edge where `strobe` is 1 and was 0 at the previous edge. Holding `strobe` high captures nothing more.
- R3: A strobe rising edge that finds the one-word buffer full is dropped, unless the buffer is emptied at that same edge. The drop sets `overflow`, which stays 1 until reset.
- R4: A slot lasts 52 `phase_ce` pulses (26 bits). Outside the boundary, each bit has `ser_clk` low in its first phase and high in its second, and the outputs change only on edges where `phase_ce` is 1.
- R5: Serial bits 1 to 24 carry `word_in[0]` to `word_in[23]` in that order (LSB first). Each bit is held through both of its phases.
- R6: Serial bit 25 is the inverse of bit 24, and serial bit 26 equals bit 24.
- R7: In a slot that carries a word, `ser_clk` stays high through both phases of bits 25 and 26. That slot therefore has exactly 24 rising edges of `ser_clk`.
- R8: A slot with no word sends `ser_data` = 0 throughout, and `ser_clk` toggles in all 26 bits (26 rising edges).
- R9: When `clear_top` is 1 at the capture edge, word bits 22 and 23 (serial bits 23 and 24) are sent as 0, and bits 25 and 26 are derived from that zeroed bit 24.
- R10: A captured word is sent in the first slot that starts after its capture edge. A strobe rising edge at the very edge that moves the buffered word into a new slot is kept without setting `overflow`.
- R11: While `enable` is 0, `ser_clk` is 1 and `ser_data` is 0. The buffered and in-flight words are discarded, strobes are ignored and `overflow` keeps its value. The first `phase_ce` after re-enable starts a new slot.
- R12: `ser_oe` equals `enable` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Serializer on; 0 forces idle output levels |
| phase_ce | input | 1 | Half-bit advance enable |
| strobe | input | 1 | Capture strobe, rising edge active |
| word_in | input | 24 | Parallel word to send |
| clear_top | input | 1 | Zero the two top word bits at capture |
| ser_clk | output | 1 | Serial bit clock with embedded word boundary |
| ser_data | output | 1 | Serial data |
| ser_oe | output | 1 | Serial output enable |
| overflow | output | 1 | Sticky dropped-word flag |

## Verification
Two events can fall on the same clock edge: a new strobe capture and the slot-start transfer that empties the buffer. The bench provokes this collision on purpose. It fills the buffer while a word is in flight, then steps the half-bit enable to the final phase of the slot and raises the strobe on the edge that starts the next slot. The collision is judged correct when `overflow` stays clear and the serial stream then delivers the buffered word followed by the colliding word, each decoded bit-exact. Random enable and strobe timing also produces the collision and the true-overflow case many times, and every cycle is compared with a transaction model.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  // Default parallel word width and the number of appended boundary bits.
  localparam int unsigned DATA_W_DEF = 24;
  localparam int unsigned GUARD_BITS = 2;
  localparam int unsigned CLR_BITS_DEF = 2;

  // Half of a serial bit: the clock is low in the first half, high in the second.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } half_e;
endpackage

// File: rtl/ewc_strobe_buf.sv
module ewc_strobe_buf #(
  parameter int unsigned DATA_W   = ewc_pkg::DATA_W_DEF,
  parameter int unsigned CLR_BITS = ewc_pkg::CLR_BITS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              strobe,
  input  logic [DATA_W-1:0] word_in,
  input  logic              clear_top,
  input  logic              drain,
  output logic              pend_valid,
  output logic [DATA_W-1:0] pend_word,
  output logic              overflow
);
  localparam int unsigned KEEP_W = DATA_W - CLR_BITS;

  logic              strobe_q;
  logic              rise;
  logic              accept;
  logic              valid_d;
  logic [DATA_W-1:0] word_d;
  logic              ovf_d;
  logic [DATA_W-1:0] masked;

  // Zero the top CLR_BITS positions when requested.
  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      masked[i] = word_in[i] & ~(clear_top && (i >= int'(KEEP_W)));
    end
  end

  always_comb begin
    rise    = strobe & ~strobe_q;
    accept  = enable & rise & (~pend_valid | drain);
    valid_d = pend_valid;
    word_d  = pend_word;
    ovf_d   = overflow;
    if (!enable) begin
      valid_d = 1'b0;
    end else begin
      if (drain) valid_d = 1'b0;
      if (accept) begin
        valid_d = 1'b1;
        word_d  = masked;
      end
      if (rise && pend_valid && !drain) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      pend_valid <= 1'b0;
      pend_word  <= '0;
      overflow   <= 1'b0;
    end else begin
      strobe_q   <= strobe;
      pend_valid <= valid_d;
      pend_word  <= word_d;
      overflow   <= ovf_d;
    end
  end
endmodule

// File: rtl/ewc_slot_timer.sv
module ewc_slot_timer #(
  parameter int unsigned SLOT_BITS = ewc_pkg::DATA_W_DEF + ewc_pkg::GUARD_BITS,
  parameter int unsigned IDX_W     = $clog2(SLOT_BITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               phase_ce,
  output logic [IDX_W-1:0]   bit_idx,
  output ewc_pkg::half_e     half,
  output logic               slot_start
);
  import ewc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOT_BITS - 1);

  logic [IDX_W-1:0] idx_d;
  half_e            half_d;
  logic             at_end;

  // The parked state (last bit, high phase) doubles as the pre-slot state.
  always_comb begin
    at_end     = (bit_idx == LAST_IDX) && (half == PH_HIGH);
    slot_start = enable & phase_ce & at_end;
    idx_d      = bit_idx;
    half_d     = half;
    if (!enable) begin
      idx_d  = LAST_IDX;
      half_d = PH_HIGH;
    end else if (phase_ce) begin
      if (half == PH_LOW) begin
        half_d = PH_HIGH;
      end else begin
        half_d = PH_LOW;
        idx_d  = (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= LAST_IDX;
      half    <= PH_HIGH;
    end else begin
      bit_idx <= idx_d;
      half    <= half_d;
    end
  end
endmodule

// File: rtl/ewc_frame_reg.sv
module ewc_frame_reg #(
  parameter int unsigned DATA_W    = ewc_pkg::DATA_W_DEF,
  parameter int unsigned SLOT_BITS = DATA_W + ewc_pkg::GUARD_BITS,
  parameter int unsigned IDX_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  bit_idx,
  input  ewc_pkg::half_e    half,
  output logic              ser_clk,
  output logic              ser_data
);
  import ewc_pkg::*;

  localparam logic [IDX_W-1:0] FIRST_GUARD = IDX_W'(DATA_W);

  logic [SLOT_BITS-1:0] frame_q;
  logic [SLOT_BITS-1:0] frame_d;
  logic                 active_q;
  logic                 active_d;
  logic                 in_guard;

  // Boundary bits: inverse of the last data bit, then the last data bit again.
  always_comb begin
    frame_d  = frame_q;
    active_d = active_q;
    if (!enable) begin
      active_d = 1'b0;
    end else if (load) begin
      active_d = word_valid;
      frame_d  = {word[DATA_W-1], ~word[DATA_W-1], word};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      active_q <= 1'b0;
    end else begin
      frame_q  <= frame_d;
      active_q <= active_d;
    end
  end

  always_comb begin
    in_guard = active_q && (bit_idx >= FIRST_GUARD);
    ser_clk  = (half == PH_HIGH) || in_guard;
    ser_data = active_q && frame_q[bit_idx];
  end
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer #(
  parameter int unsigned DATA_W   = ewc_pkg::DATA_W_DEF,
  parameter int unsigned CLR_BITS = ewc_pkg::CLR_BITS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              phase_ce,
  input  logic              strobe,
  input  logic [DATA_W-1:0] word_in,
  input  logic              clear_top,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_oe,
  output logic              overflow
);
  import ewc_pkg::*;

  localparam int unsigned SLOT_BITS = DATA_W + GUARD_BITS;
  localparam int unsigned IDX_W     = $clog2(SLOT_BITS);

  logic              slot_start;
  logic              pend_valid;
  logic [DATA_W-1:0] pend_word;
  logic [IDX_W-1:0]  bit_idx;
  half_e             half;

  ewc_strobe_buf #(.DATA_W(DATA_W), .CLR_BITS(CLR_BITS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .strobe    (strobe),
    .word_in   (word_in),
    .clear_top (clear_top),
    .drain     (slot_start),
    .pend_valid(pend_valid),
    .pend_word (pend_word),
    .overflow  (overflow)
  );

  ewc_slot_timer #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .phase_ce  (phase_ce),
    .bit_idx   (bit_idx),
    .half      (half),
    .slot_start(slot_start)
  );

  ewc_frame_reg #(.DATA_W(DATA_W), .SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load      (slot_start),
    .word_valid(pend_valid),
    .word      (pend_word),
    .bit_idx   (bit_idx),
    .half      (half),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data)
  );

  logic oe_d;
  always_comb oe_d = enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_oe <= 1'b0;
    else        ser_oe <= oe_d;
  end
endmodule

// File: rtl/emb_clk_serializer_chk.sv
module emb_clk_serializer_chk #(
  parameter int unsigned DATA_W = ewc_pkg::DATA_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              phase_ce,
  input logic              strobe,
  input logic [DATA_W-1:0] word_in,
  input logic              clear_top,
  input logic              ser_clk,
  input logic              ser_data,
  input logic              ser_oe,
  input logic              overflow
);
  logic unused_ok;
  always_comb unused_ok = ^{word_in, clear_top};

  p_idle_levels_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe |-> (ser_clk && !ser_data));

  p_oe_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ser_oe);

  p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ser_oe);

  p_no_overflow_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_overflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(strobe) && $past(enable)));

  p_hold_without_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !phase_ce) |=> ($stable(ser_clk) && $stable(ser_data)));
endmodule

bind emb_clk_serializer emb_clk_serializer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .phase_ce (phase_ce),
  .strobe   (strobe),
  .word_in  (word_in),
  .clear_top(clear_top),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_oe   (ser_oe),
  .overflow (overflow)
);

// File: tb/emb_clk_serializer_tb_top.sv
`timescale 1ns/1ps
module emb_clk_serializer_tb_top;
  logic        clk;
  logic        rst_n;
  logic        en_r, ce_r, strobe_r, clr_r;
  logic [23:0] data_r;
  logic        ser_clk, ser_data, ser_oe, overflow;

  emb_clk_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(en_r), .phase_ce(ce_r), .strobe(strobe_r),
    .word_in(data_r), .clear_top(clr_r), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_oe(ser_oe), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Transaction model state
  int          m_ph;
  logic        m_act, m_pv, m_ovf, m_oe, m_strobe_q, m_started;
  logic [23:0] m_pw;
  logic [25:0] m_frame;
  int          m_drains, n_word_slots;
  // Stream monitor
  logic [25:0] cur_bits, last_bits;
  int          cur_rises, last_rises, last_idle_rises;
  logic        prev_clk;
  int          e_r3, e_r4, e_r5, e_r6, e_r7, e_r8, e_r11, e_r12;

  function automatic logic [25:0] mk_frame(logic [23:0] w);
    return {w[23], ~w[23], w};
  endfunction

  function automatic logic [23:0] mask_word(logic [23:0] w, logic clr);
    return clr ? (w & 24'h3FFFFF) : w;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 51; m_act = 0; m_pv = 0; m_ovf = 0; m_oe = 0; m_strobe_q = 0;
    m_started = 0; m_pw = '0; m_frame = '0; cur_rises = 0; cur_bits = '0;
  endtask

  task automatic model_edge();
    logic rise, drain;
    rise = strobe_r & ~m_strobe_q;
    m_strobe_q = strobe_r;
    if (!en_r) begin
      m_ph = 51; m_act = 0; m_pv = 0; m_started = 0; m_oe = 0;
    end else begin
      m_oe  = 1;
      drain = ce_r && (m_ph == 51);
      if (rise && m_pv && !drain) m_ovf = 1;
      if (drain) begin
        if (m_started && m_act) begin
          last_bits = cur_bits; last_rises = cur_rises; n_word_slots++;
        end else if (m_started) begin
          last_idle_rises = cur_rises;
        end
        m_act = m_pv; m_frame = mk_frame(m_pw); m_started = 1;
        cur_rises = 0; cur_bits = '0; m_drains++;
      end
      if (rise && (!m_pv || drain)) begin
        m_pv = 1; m_pw = mask_word(data_r, clr_r);
      end else if (drain) begin
        m_pv = 0;
      end
      if (ce_r) m_ph = (m_ph == 51) ? 0 : m_ph + 1;
    end
  endtask

  task automatic compare();
    logic exp_clk, exp_data;
    int b;
    b = m_ph / 2;
    if (!m_oe) begin
      exp_clk = 1'b1; exp_data = 1'b0;
      if (ser_clk !== exp_clk || ser_data !== exp_data) e_r11++;
    end else if (!m_act) begin
      exp_clk = 1'(m_ph % 2); exp_data = 1'b0;
      if (ser_clk !== exp_clk || ser_data !== exp_data) e_r8++;
    end else if (b < 24) begin
      exp_clk = 1'(m_ph % 2); exp_data = m_frame[b];
      if (ser_clk !== exp_clk) e_r4++;
      if (ser_data !== exp_data) e_r5++;
    end else begin
      exp_clk = 1'b1; exp_data = m_frame[b];
      if (ser_clk !== exp_clk) e_r7++;
      if (ser_data !== exp_data) e_r6++;
    end
    if (ser_oe !== m_oe) e_r12++;
    if (overflow !== m_ovf) e_r3++;
    if (m_started && m_oe) begin
      if (ser_clk && !prev_clk) cur_rises++;
      if (m_ph % 2 == 1) cur_bits[b] = ser_data;
    end
    prev_clk = ser_clk;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_slots(int n);
    int target;
    target = m_drains + n;
    while (m_drains < target) step();
  endtask

  task automatic pulse(logic [23:0] w, logic clr);
    data_r = w; clr_r = clr; strobe_r = 1'b1; step();
    strobe_r = 1'b0; step();
  endtask

  initial begin
    int base;
    logic [23:0] wc;
    void'($urandom(32'd20240611));
    en_r = 0; ce_r = 0; strobe_r = 0; clr_r = 0; data_r = '0;
    m_drains = 0; n_word_slots = 0; last_bits = '0; last_rises = 0; last_idle_rises = 0;
    prev_clk = 1'b1;
    e_r3 = 0; e_r4 = 0; e_r5 = 0; e_r6 = 0; e_r7 = 0; e_r8 = 0; e_r11 = 0; e_r12 = 0;
    do_reset();
    step();
    // R1 reset state
    check(ser_clk === 1'b1 && ser_data === 1'b0, "R1 serial levels", {ser_clk, ser_data}, 2'b10);
    check(ser_oe === 1'b0 && overflow === 1'b0, "R1 oe/overflow", {ser_oe, overflow}, 2'b00);

    en_r = 1; ce_r = 1; step();
    check(ser_oe === 1'b1, "R12 oe follows enable", ser_oe, 1);

    // Table-style word: last data bit 0 gives boundary bits 1 then 0
    pulse(24'h3FFFFF, 1'b0);
    run_slots(3);
    check(last_bits === 26'h13FFFFF, "R5 R6 word bits", last_bits, 26'h13FFFFF);
    check(last_rises == 24, "R7 rising edges in word slot", last_rises, 24);
    check(last_idle_rises == 26, "R8 rising edges in idle slot", last_idle_rises, 26);

    // R9 top-bit clearing
    pulse(24'hFFFFFF, 1'b1);
    run_slots(2);
    check(last_bits === 26'h13FFFFF, "R9 top bits cleared", last_bits, 26'h13FFFFF);

    // R2 level-held strobe captures once
    base = n_word_slots;
    data_r = 24'hA5C3E1; clr_r = 0; strobe_r = 1; step();
    run_slots(3);
    strobe_r = 0;
    run_slots(2);
    check(n_word_slots - base == 1, "R2 single capture on held strobe", n_word_slots - base, 1);

    // R10 collision: capture on the slot-start edge with buffer full
    pulse(24'h111111, 1'b0);
    run_slots(1);                       // first word now in flight
    pulse(24'h222222, 1'b0);            // fills buffer
    while (m_ph != 51) step();
    wc = 24'h80F00D;
    data_r = wc; strobe_r = 1; step(); // slot start and rise on the same edge
    strobe_r = 0; step();
    check(overflow === 1'b0, "R10 no overflow on collision", overflow, 0);
    run_slots(1);
    check(last_bits === mk_frame(24'h222222), "R10 buffered word sent", last_bits, mk_frame(24'h222222));
    run_slots(1);
    check(last_bits === mk_frame(wc), "R10 colliding word sent", last_bits, mk_frame(wc));

    // R11 disable mid-word
    pulse(24'h5A5A5A, 1'b0);
    run_slots(1);
    repeat (7) step();
    en_r = 0; step();
    check(ser_clk === 1'b1 && ser_data === 1'b0 && ser_oe === 1'b0, "R11 forced idle",
          {ser_clk, ser_data, ser_oe}, 3'b100);
    pulse(24'h777777, 1'b0);            // ignored while disabled
    en_r = 1;
    base = n_word_slots;
    run_slots(3);
    check(n_word_slots == base, "R11 no word after re-enable", n_word_slots - base, 0);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      ce_r     = ($urandom % 4) != 0;
      en_r     = ($urandom % 700) != 0;
      clr_r    = $urandom % 2;
      data_r   = 24'($urandom);
      strobe_r = ($urandom % 40) == 0 ? ~strobe_r : (strobe_r & (($urandom % 3) != 0));
      step();
    end
    strobe_r = 0; en_r = 1; ce_r = 1;
    run_slots(2);
    check(n_word_slots > 20, "R10 words delivered under random timing", n_word_slots, 20);

    // R3 sticky overflow
    do_reset();
    en_r = 1; ce_r = 0; step();
    pulse(24'h000001, 1'b0);
    check(overflow === 1'b0, "R3 first word buffered", overflow, 0);
    pulse(24'h000002, 1'b0);
    check(overflow === 1'b1, "R3 overflow on full buffer", overflow, 1);
    ce_r = 1; run_slots(2);
    en_r = 0; step(); en_r = 1; step();
    check(overflow === 1'b1, "R3 overflow sticky", overflow, 1);
    do_reset();
    step();
    check(overflow === 1'b0, "R1 overflow cleared by reset", overflow, 0);

    check(e_r3 == 0, "R3 overflow tracking", e_r3, 0);
    check(e_r4 == 0, "R4 clock phases", e_r4, 0);
    check(e_r5 == 0, "R5 data bits", e_r5, 0);
    check(e_r6 == 0, "R6 boundary bits", e_r6, 0);
    check(e_r7 == 0, "R7 boundary clock", e_r7, 0);
    check(e_r8 == 0, "R8 idle slots", e_r8, 0);
    check(e_r11 == 0, "R11 disabled levels", e_r11, 0);
    check(e_r12 == 0, "R12 output enable", e_r12, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule